// File: doc/BRIEF.md
# MCU Reset Qualifier and Controller

This block decides when an 8-bit microcontroller core is held in reset. An active-high reset pin is brought into the clock domain through a two-stage synchroniser. A pulse is then accepted as a reset only after the synchronised level has stayed high for a set number of consecutive clocks, 24 by default, which is two machine cycles. Shorter glitches are dropped completely. While reset is active the block asserts the core reset and forces the program-counter value handed to the core to zero, so that execution restarts at address zero. It also overrides the external address-latch strobe and the program-fetch strobe to a high level. On the first cycle of every accepted reset it issues a one-cycle strobe that returns the special-function registers to their reset values. It drives no memory clear or write signal, so data RAM keeps its contents across a reset.

The block also holds a sticky power-on flag. A separate asynchronous power-up input sets the flag. Software clears it by writing a zero to it. External resets and the chip-level housekeeping reset leave the flag untouched, so software can tell a cold start from a warm one.

Top module: `mcu_rst_ctrl`

## Requirements
- R1: A reset is accepted only when `ext_rst` has been high at 24 consecutive rising clock edges. If the first high sample is taken at edge E0 and the level stays high, `core_rst` goes high after edge E25, two cycles later than the last qualifying sample because of the synchroniser.
- R2: A high pulse seen at 23 or fewer consecutive edges, or any run broken by a single low sample, produces no `core_rst`, no `sfr_rst_stb`, no strobe override and no change to `pwr_flag`.
- R3: Once accepted, `core_rst` stays high as long as the synchronised input stays high. It falls after the second rising edge that follows the first low sample of `ext_rst`. A pulse held for N ≥ 24 samples therefore gives N−23 cycles of `core_rst`.
- R4: While `core_rst` is high, `pc_out` is zero. Otherwise `pc_out` equals `pc_in`.
- R5: While `core_rst` is high, `ale_out` and `psen_out` are both 1. Otherwise they follow `ale_in` and `psen_in`.
- R6: `sfr_rst_stb` is high for exactly one cycle, the first cycle of each accepted reset, and never outside reset.
- R7: `pwr_flag` is set to 1 asynchronously while `pwr_up` is high. It keeps its value through external resets and through `rst_n`, and an external reset never sets it.
- R8: At a rising edge with `reg_we`=1 and `reg_wbit`=0, `pwr_flag` clears to 0. A write with `reg_wbit`=1 leaves it unchanged.
- R9: When `rst_n` is low at a rising edge, the synchroniser and the qualifier clear, so `core_rst` and `sfr_rst_stb` are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low housekeeping reset |
| pwr_up | input | 1 | Asynchronous power-up indication, active high |
| ext_rst | input | 1 | Raw external reset pin, active high |
| reg_we | input | 1 | Register write enable for the power-on flag |
| reg_wbit | input | 1 | Value written to the power-on flag bit (0 clears) |
| ale_in | input | 1 | Address-latch strobe from the core |
| psen_in | input | 1 | Program-fetch strobe from the core |
| pc_in | input | PC_W | Program-counter value from the core |
| core_rst | output | 1 | Core reset, active high |
| sfr_rst_stb | output | 1 | One-cycle register-reset strobe |
| ale_out | output | 1 | Address-latch strobe to the pin |
| psen_out | output | 1 | Program-fetch strobe to the pin |
| pc_out | output | PC_W | Program-counter value to the core |
| pwr_flag | output | 1 | Sticky power-on flag |

## Verification
The qualifier is driven with high pulses of 23 and 24 samples, which separates an off-by-one in the count limit or in the synchroniser depth. A 15+15 run split by one low sample shows whether the count restarts on any low. Long holds of 28, 30 and 40 samples expose errors in the release timing, because the length of `core_rst` must be exactly N−23. The power-on flag is tried with writes of one and of zero, with resets that come after a clear and after a fresh power-up, and with a mid-cycle power-up pulse, which together separate stickiness from asynchronous setting.

// File: rtl/mcu_rst_pkg.sv
// Package: shared constants and types for the reset controller.
// Assumes: one machine cycle is twelve oscillator clocks.
package mcu_rst_pkg;
    localparam int unsigned MACH_CYC_CLKS  = 12;
    localparam int unsigned DEF_QUAL_CLKS  = 2 * MACH_CYC_CLKS;
    localparam int unsigned DEF_SYNC_DEPTH = 2;
    localparam int unsigned DEF_PC_W       = 16;

    // Pair of external bus strobes handled together.
    typedef struct packed {
        logic ale;
        logic psen;
    } bus_strb_t;
endpackage

// File: rtl/rst_sync.sv
// Module: rst_sync
// Brings an asynchronous level into the clock domain with a chain of flops.
// Assumes: STAGES >= 2; the synchronous reset clears the chain to 0.
module rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rst_qualifier.sv
// Module: rst_qualifier
// Counts consecutive high samples of the synchronised reset level and
// accepts a reset when QUAL_CLKS samples in a row were high. The accepted
// reset lasts while the level stays high and drops one edge after a low.
// Assumes: QUAL_CLKS >= 2; input is already synchronous to clk.
module rst_qualifier #(
    parameter int unsigned QUAL_CLKS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rst_act,
    output logic rst_stb
);
    localparam int unsigned CW = $clog2(QUAL_CLKS);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CLKS - 1);

    logic [CW-1:0] run_cnt;
    logic          run_full;

    assign run_full = (run_cnt == LAST);

    // Saturating count of consecutive high samples; restart on a low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!lvl) begin
            run_cnt <= '0;
        end else if (!run_full) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Reset state: enter on the qualifying sample, hold while high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_act <= 1'b0;
            rst_stb <= 1'b0;
        end else begin
            rst_act <= lvl && (rst_act || run_full);
            rst_stb <= lvl && !rst_act && run_full;
        end
    end

    AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_act) |-> $past(run_cnt) == LAST);                 // R1
    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_act && lvl) |=> rst_act);                              // R3
    AST_RELEASE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl |=> !rst_act);                                         // R3
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_stb |=> !rst_stb);                                      // R6
    AST_STB_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_stb |-> rst_act);                                       // R6
endmodule

// File: rtl/por_flag.sv
// Module: por_flag
// Sticky power-on flag: set asynchronously by the power-up input, cleared
// only by a software clear request. No other reset touches it.
// Assumes: the clear request is synchronous to clk.
module por_flag (
    input  logic clk,
    input  logic pwr_up,
    input  logic clr_req,
    output logic flag
);
    // Asynchronous set on power-up, synchronous software clear.
    always_ff @(posedge clk or posedge pwr_up) begin
        if (pwr_up) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (pwr_up)
        (flag && !clr_req) |=> flag);                               // R7
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (pwr_up)
        clr_req |=> !flag);                                         // R8
endmodule

// File: rtl/mcu_rst_ctrl.sv
// Module: mcu_rst_ctrl (top)
// Qualifies the external reset pin, drives the core reset, zeroes the
// program counter and forces the bus strobes high during reset, issues
// the register-reset strobe and keeps the sticky power-on flag.
// Assumes: rst_n is a synchronous housekeeping reset; pwr_up is async.
module mcu_rst_ctrl
    import mcu_rst_pkg::*;
#(
    parameter int unsigned QUAL_CLKS  = DEF_QUAL_CLKS,
    parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH,
    parameter int unsigned PC_W       = DEF_PC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_up,
    input  logic            ext_rst,
    input  logic            reg_we,
    input  logic            reg_wbit,
    input  logic            ale_in,
    input  logic            psen_in,
    input  logic [PC_W-1:0] pc_in,
    output logic            core_rst,
    output logic            sfr_rst_stb,
    output logic            ale_out,
    output logic            psen_out,
    output logic [PC_W-1:0] pc_out,
    output logic            pwr_flag
);
    logic      ext_sync;
    logic      in_reset;
    logic      clr_req;
    bus_strb_t strb_core;
    bus_strb_t strb_pin;

    rst_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ext_rst),
        .q_sync  (ext_sync)
    );

    rst_qualifier #(.QUAL_CLKS(QUAL_CLKS)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (ext_sync),
        .rst_act (in_reset),
        .rst_stb (sfr_rst_stb)
    );

    assign clr_req = reg_we && !reg_wbit;

    por_flag u_flag (
        .clk     (clk),
        .pwr_up  (pwr_up),
        .clr_req (clr_req),
        .flag    (pwr_flag)
    );

    // Override strobes and program counter while the core is held.
    always_comb begin
        strb_core.ale  = ale_in;
        strb_core.psen = psen_in;
        strb_pin       = in_reset ? '{ale: 1'b1, psen: 1'b1} : strb_core;
        pc_out         = in_reset ? '0 : pc_in;
    end

    assign core_rst = in_reset;
    assign ale_out  = strb_pin.ale;
    assign psen_out = strb_pin.psen;
endmodule

// File: tb/mcu_rst_ctrl_tb.sv
module mcu_rst_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL = 24;
    localparam int PCW  = 16;

    logic clk = 1'b0;
    logic rst_n, pwr_up, ext_rst, reg_we, reg_wbit, ale_in, psen_in;
    logic [PCW-1:0] pc_in;
    logic core_rst, sfr_rst_stb, ale_out, psen_out, pwr_flag;
    logic [PCW-1:0] pc_out;

    int checks = 0, errors = 0, cyc = 0, rst_cycles = 0, stb_count = 0;
    bit started = 0, done = 0;

    // Behavioural reference state
    bit hist[$] = '{1'b0, 1'b0};
    int run = 0;
    bit m_act = 0, m_stb = 0, m_flag = 0, d;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcu_rst_ctrl #(.QUAL_CLKS(QUAL), .PC_W(PCW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .ext_rst(ext_rst),
        .reg_we(reg_we), .reg_wbit(reg_wbit), .ale_in(ale_in),
        .psen_in(psen_in), .pc_in(pc_in), .core_rst(core_rst),
        .sfr_rst_stb(sfr_rst_stb), .ale_out(ale_out), .psen_out(psen_out),
        .pc_out(pc_out), .pwr_flag(pwr_flag)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic pulse(input int n);
        ext_rst = 1'b1;
        step(n);
        ext_rst = 1'b0;
    endtask

    // Reference model update at each rising edge
    always @(posedge clk) begin
        started = 1;
        if (pwr_up) m_flag = 1;
        else if (reg_we && !reg_wbit) m_flag = 0;
        if (!rst_n) begin
            hist = '{1'b0, 1'b0};
            run = 0; m_act = 0; m_stb = 0;
        end else begin
            d = hist[0];
            void'(hist.pop_front());
            hist.push_back(ext_rst);
            if (d) begin
                m_stb = !m_act && (run >= QUAL - 1);
                if (m_stb) m_act = 1;
                run++;
            end else begin
                m_act = 0; m_stb = 0; run = 0;
            end
        end
    end

    always @(posedge pwr_up) m_flag = 1;

    // Per-cycle comparison, then new core-side stimulus
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1/R3 core_rst", core_rst, m_act);
            chk("R6 sfr_rst_stb", sfr_rst_stb, m_stb);
            chk("R5 ale_out", ale_out, m_act | ale_in);
            chk("R5 psen_out", psen_out, m_act | psen_in);
            chk("R4 pc_out", pc_out, m_act ? 0 : pc_in);
            chk("R7/R8 pwr_flag", pwr_flag, m_flag);
            if (core_rst) rst_cycles++;
            if (sfr_rst_stb) stb_count++;
        end
        #1;
        cyc++;
        ale_in  = cyc[0];
        psen_in = cyc[1];
        pc_in   = PCW'(cyc * 37 + 5);
    end

    initial begin
        int r0, s0;
        rst_n = 0; ext_rst = 0; pwr_up = 1; reg_we = 0; reg_wbit = 1;
        ale_in = 0; psen_in = 0; pc_in = '0;
        step(3);
        chk("R9 reset core_rst", core_rst, 0);
        chk("R9 reset stb", sfr_rst_stb, 0);
        chk("R7 power-up flag", pwr_flag, 1);
        rst_n = 1; pwr_up = 0;
        step(5);

        r0 = rst_cycles; s0 = stb_count;
        pulse(23); step(30);
        chk("R2 23-clock pulse core_rst", rst_cycles - r0, 0);
        chk("R2 23-clock pulse stb", stb_count - s0, 0);
        chk("R2 23-clock pulse flag", pwr_flag, 1);

        r0 = rst_cycles;
        pulse(15); step(1); pulse(15); step(30);
        chk("R2 interrupted run", rst_cycles - r0, 0);

        r0 = rst_cycles; s0 = stb_count;
        pulse(24); step(30);
        chk("R1 24-clock pulse length", rst_cycles - r0, 1);
        chk("R6 one strobe per reset", stb_count - s0, 1);

        r0 = rst_cycles;
        pulse(30); step(30);
        chk("R3 30-sample hold length", rst_cycles - r0, 7);

        ext_rst = 1; step(28);
        chk("R1 held reset core_rst", core_rst, 1);
        chk("R5 ale forced", ale_out, 1);
        chk("R5 psen forced", psen_out, 1);
        chk("R4 pc zero", pc_out, 0);
        ext_rst = 0; step(5);

        reg_we = 1; reg_wbit = 1; step(1); reg_we = 0;
        chk("R8 write of one keeps flag", pwr_flag, 1);
        reg_we = 1; reg_wbit = 0; step(1); reg_we = 0; reg_wbit = 1;
        chk("R8 write of zero clears flag", pwr_flag, 0);
        pulse(40); step(5);
        chk("R7 external reset leaves flag clear", pwr_flag, 0);
        #2 pwr_up = 1;
        #1 chk("R7 async set", pwr_flag, 1);
        pwr_up = 0;
        step(1);
        pulse(30); step(5);
        chk("R7 flag survives external reset", pwr_flag, 1);

        ext_rst = 1; step(30);
        chk("R9 in reset before rst_n", core_rst, 1);
        rst_n = 0; step(1);
        chk("R9 rst_n clears core_rst", core_rst, 0);
        chk("R7 flag survives rst_n", pwr_flag, 1);
        rst_n = 1; ext_rst = 0; step(5);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog got %0d exp %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule